// File: doc/BRIEF.md
# External Pin Interrupt Sense Controller

This block watches eight asynchronous external interrupt pins and one non-maskable interrupt pin. Each pin first passes through a two-flop synchroniser. After that, the pin is checked for the event that its software-selected sense code asks for. Every detected event sets a sticky bit in a status register. Each status bit is also driven out as a level-high request toward a parent interrupt controller. The request stays high until software clears the bit.

Software reaches the block through a plain register strobe port. A write strobe carries an address and write data. Read data is returned combinationally for the address presented. There are two registers:

- **Sense-select register.** It holds a 2-bit sense code for each external pin.
- **Status register.** It holds one sticky bit per pin. A bit is cleared by writing 0 to it, so software clears one bit with a read-modify-write and leaves every other bit as 1.

The non-maskable pin has a fixed rising-edge sense. It has its own status bit and its own request output.

Top module: `ext_irq_sense`

## Requirements
- R1: After reset, the status register and the sense-select register read as zero, every request output is low, and all synchroniser stages hold logic high.
- R2: The sense-select register is at offset 0x14. Pin n uses bits [2n+1:2n]. A write replaces all sixteen bits. Bits 31..16 read as zero.
- R3: Sense code 0 (level low) sets status bit n in every cycle that the synchronised pin is low. A clear written while the pin is still low does not hold. A clear written after the pin is back high does hold.
- R4: Sense code 1 (falling edge) sets status bit n on a high-to-low change of the synchronised pin. A low-to-high change has no effect.
- R5: Sense code 2 (rising edge) sets status bit n on a low-to-high change of the synchronised pin. A high-to-low change has no effect.
- R6: Sense code 3 (both edges) sets status bit n on either change of the synchronised pin.
- R7: The status register is at offset 0x10. Bit n belongs to external pin n. Writing 0 to a bit clears it. Writing 1 leaves it unchanged. A set bit stays set until it is cleared.
- R8: If a pin event and a clear of the same status bit fall in the same cycle, the bit stays set.
- R9: irq_req[n] is active high and equals status bit n, whatever sense code pin n uses.
- R10: The non-maskable pin is sensed on its synchronised rising edge. It sets status bit 16, which is cleared by writing 0. nmi_req equals that bit.
- R11: A pin change that is driven before clock edge k is reflected in status and in the request after edge k+2, and not before.
- R12: A write to any offset other than 0x10 or 0x14 changes nothing. Such offsets read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_in | input | 8 | Asynchronous external interrupt pins |
| nmi_in | input | 1 | Asynchronous non-maskable interrupt pin |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq_req | output | 8 | Level-high request per external pin |
| nmi_req | output | 1 | Level-high non-maskable request |

## Verification
Two things can land on the same status bit in one clock: the software write that clears the bit, and a new event on the pin. The bench forces this on purpose:

- In both-edges mode, it sets a bit, toggles the pin, waits exactly the two synchroniser cycles, and then issues the clear in the cycle where the event lands. The bit must read back as set.
- In level-low mode, it clears the bit while the pin is still held low. The bit must again survive.

Random writes, mixed with random pin toggles, hit further collisions. Each one is judged against a bench model that applies the clear first and ORs the event in afterwards.

// File: rtl/ext_irq_sense.sv
module ext_irq_sense #(
  parameter int NUM_PINS = 8,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] STAT_OFS = 'h10,
  parameter logic [ADDR_W-1:0] SENSE_OFS = 'h14,
  parameter int NMI_BIT = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_in,
  input  logic                nmi_in,
  input  logic                reg_wr,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  output logic [NUM_PINS-1:0] irq_req,
  output logic                nmi_req
);
  localparam int SENSE_W = 2 * NUM_PINS;
  localparam int SYNC_W = NUM_PINS + 1;

  logic [SYNC_W-1:0]   s1, s2, s3;
  logic [SENSE_W-1:0]  sense;
  logic [NUM_PINS-1:0] stat, evt;
  logic                nmi_st, nmi_evt;
  logic                wr_stat, wr_sense;
  logic [DATA_W-1:0]   stat_word;
  logic                wdata_unused;

  assign wr_stat  = reg_wr && (reg_addr == STAT_OFS);
  assign wr_sense = reg_wr && (reg_addr == SENSE_OFS);
  assign wdata_unused = ^reg_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '1;
      s2 <= '1;
      s3 <= '1;
    end else begin
      s1 <= {nmi_in, pin_in};
      s2 <= s1;
      s3 <= s2;
    end
  end

  genvar g;
  generate
    for (g = 0; g < NUM_PINS; g++) begin : g_pin
      always_comb begin
        unique case (sense[2*g +: 2])
          2'd0: evt[g] = ~s2[g];
          2'd1: evt[g] = ~s2[g] & s3[g];
          2'd2: evt[g] = s2[g] & ~s3[g];
          default: evt[g] = s2[g] ^ s3[g];
        endcase
      end

      a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (stat[g] && !(wr_stat && !reg_wdata[g])) |=> stat[g]);
      a_r8_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        evt[g] |=> stat[g]);
    end
  endgenerate

  assign nmi_evt = s2[NUM_PINS] & ~s3[NUM_PINS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sense  <= '0;
      stat   <= '0;
      nmi_st <= 1'b0;
    end else begin
      if (wr_sense) sense <= reg_wdata[SENSE_W-1:0];
      stat   <= (wr_stat ? (stat & reg_wdata[NUM_PINS-1:0]) : stat) | evt;
      nmi_st <= (wr_stat ? (nmi_st & reg_wdata[NMI_BIT]) : nmi_st) | nmi_evt;
    end
  end

  always_comb begin
    stat_word = '0;
    stat_word[NUM_PINS-1:0] = stat;
    stat_word[NMI_BIT] = nmi_st;
  end

  assign reg_rdata = (reg_addr == STAT_OFS)  ? stat_word :
                     (reg_addr == SENSE_OFS) ? DATA_W'(sense) : '0;
  assign irq_req = stat;
  assign nmi_req = nmi_st;

  a_r1_reset_clear: assert property (@(posedge clk)
    $rose(rst_n) |-> (stat == '0 && sense == '0 && !nmi_st));
  a_r2_sense_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sense |=> sense == $past(reg_wdata[SENSE_W-1:0]));
  a_r10_nmi_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_st && !(wr_stat && !reg_wdata[NMI_BIT])) |=> nmi_st);
  a_r12_no_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_sense) |=> $stable(sense));
endmodule

// File: tb/ext_irq_sense_test.sv
module ext_irq_sense_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [7:0]  pins = 8'hFF;
  logic        nmi = 0;
  logic        wr = 0;
  logic [7:0]  addr = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic [7:0]  irq_req;
  logic        nmi_req;

  int nchk = 0, nfail = 0;
  logic [8:0]  m1 = '1, m2 = '1, m3 = '1;
  logic [31:0] m_stat = 0;
  logic [15:0] m_sense = 0;

  always #5 clk = ~clk;

  ext_irq_sense uut (.clk(clk), .rst_n(rst_n), .pin_in(pins), .nmi_in(nmi),
    .reg_wr(wr), .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata),
    .irq_req(irq_req), .nmi_req(nmi_req));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic evt_of(input logic [1:0] mode, input logic cur, input logic old);
    case (mode)
      2'd0: return ~cur;
      2'd1: return ~cur & old;
      2'd2: return cur & ~old;
      default: return cur ^ old;
    endcase
  endfunction

  function automatic logic [31:0] model_read(input logic [7:0] a);
    if (a == 8'h10) return m_stat;
    if (a == 8'h14) return {16'b0, m_sense};
    return 32'b0;
  endfunction

  task automatic tick();
    logic [8:0]  ev;
    logic [31:0] nst;
    logic [15:0] nse;
    for (int i = 0; i < 8; i++) ev[i] = evt_of(m_sense[2*i +: 2], m2[i], m3[i]);
    ev[8] = m2[8] & ~m3[8];
    nst = m_stat;
    nse = m_sense;
    if (wr && addr == 8'h10) nst = nst & wdata & 32'h0001_00FF;
    if (wr && addr == 8'h14) nse = wdata[15:0];
    nst = nst | {15'b0, ev[8], 8'b0, ev[7:0]};
    @(posedge clk);
    m3 = m2; m2 = m1; m1 = {nmi, pins};
    m_stat = nst; m_sense = nse;
    @(negedge clk);
    wr = 0;
    check("R9 irq_req", {24'b0, irq_req}, {24'b0, m_stat[7:0]});
    check("R10 nmi_req", {31'b0, nmi_req}, {31'b0, m_stat[16]});
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wreg(input logic [7:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr = 1;
    tick();
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    summary();
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(8'h10, d); check("R1 status reset", d, 32'h0);
    rd(8'h14, d); check("R1 sense reset", d, 32'h0);
    check("R1 requests reset", {23'b0, nmi_req, irq_req}, 32'h0);

    wreg(8'h14, 32'hFFFF_FFFF);
    rd(8'h14, d); check("R2 sense upper bits zero", d, 32'h0000_FFFF);
    wreg(8'h14, 32'h0000_004E);
    rd(8'h14, d); check("R2 sense readback", d, 32'h0000_004E);

    pins[0] = 0; ticks(4);
    rd(8'h10, d); check("R5 falling ignored in rising mode", d, 32'h0);
    pins[0] = 1; ticks(2);
    rd(8'h10, d); check("R11 not yet after two edges", d, 32'h0);
    tick();
    rd(8'h10, d); check("R5 R11 rising sets after third edge", d, 32'h1);

    wreg(8'h10, 32'hFFFF_FFFF);
    rd(8'h10, d); check("R7 write one keeps bit", d, 32'h1);
    wreg(8'h10, 32'hFFFF_FFFE);
    rd(8'h10, d); check("R7 write zero clears", d, 32'h0);

    pins[1] = 0; ticks(3);
    rd(8'h10, d); check("R6 falling in both mode", d, 32'h2);
    pins[1] = 1; ticks(2);
    wreg(8'h10, 32'h0);
    rd(8'h10, d); check("R8 event beats same cycle clear", d, 32'h2);
    wreg(8'h10, 32'h0);
    rd(8'h10, d); check("R7 clear after collision", d, 32'h0);

    pins[3] = 0; ticks(3);
    rd(8'h10, d); check("R4 falling sets", d, 32'h8);
    wreg(8'h10, 32'h0);
    pins[3] = 1; ticks(4);
    rd(8'h10, d); check("R4 rising ignored", d, 32'h0);

    pins[2] = 0; ticks(3);
    rd(8'h10, d); check("R3 level low sets", d, 32'h4);
    check("R9 request follows status", {24'b0, irq_req}, 32'h4);
    wreg(8'h10, 32'h0);
    rd(8'h10, d); check("R3 clear while low does not hold", d, 32'h4);
    pins[2] = 1; ticks(3);
    wreg(8'h10, 32'h0); ticks(2);
    rd(8'h10, d); check("R3 clear holds once high", d, 32'h0);

    nmi = 1; ticks(3);
    rd(8'h10, d); check("R10 nmi status bit", d, 32'h0001_0000);
    check("R10 nmi_req high", {31'b0, nmi_req}, 32'h1);
    wreg(8'h10, 32'hFFFE_FFFF);
    rd(8'h10, d); check("R10 nmi clear", d, 32'h0);

    wreg(8'h18, 32'hFFFF_FFFF);
    rd(8'h14, d); check("R12 sense untouched", d, 32'h0000_004E);
    rd(8'h10, d); check("R12 status untouched", d, 32'h0);
    rd(8'h18, d); check("R12 unmapped reads zero", d, 32'h0);

    for (int n = 0; n < 3000; n++) begin
      logic [7:0] a;
      for (int i = 0; i < 8; i++) if ($urandom % 8 == 0) pins[i] = ~pins[i];
      if ($urandom % 16 == 0) nmi = ~nmi;
      case ($urandom % 3)
        0: a = 8'h10;
        1: a = 8'h14;
        default: a = 8'h18;
      endcase
      rd(a, d);
      check("R2 R7 R12 random read", d, model_read(a));
      if ($urandom % 4 == 0) begin
        wdata = $urandom;
        wr = 1;
      end
      tick();
    end
    summary();
  end
endmodule